// File: doc/BRIEF.md
# Spare-Area Page State and Sector Skip Mask

This block keeps the spare-area state that a flash page controller consults around every page program and page read. It holds a 32-bit control word. The low 9 bits give the spare-area size in bytes. The upper 16 bits are a skip mask with one bit per ECC sector. It also holds a small spare-word store, and word 0 of that store carries the erased/dirty marker in its upper half.

For a partial program, the block works out which sectors the write touches and clears only their mask bits. The ECC engine then generates parity only for those sectors, and the data path pads the other sectors with 0xFF. Parity words from the engine are kept only for unmasked sectors. A full-page program clears the marker so the page later reads back as written. A page read first inspects the marker: an erased page produces no transfer and its data is returned as all ones. The spare store can be set to all 0xFF in one cycle before user spare bytes are loaded.

Top module: `sa_page_state`

## Requirements
- R1: After reset the control word is 0, every spare word reads 0xFFFFFFFF, and a read request reports the page erased with no transfer start.
- R2: A configuration load stores the spare size in control bits 8:0, together with the sector size as log2 bytes and the sector count (1 to 16). Bits 15:9 of the control word read 0.
- R3: A partial write request with offset O and length L, sector size S, sets control bits 31:16 to all ones and then clears bit 16+i for every sector i with floor(O/S) <= i < ceil((floor(O/S)*S+L)/S). The change is visible one cycle after the request. `sect_par_en` gives, for each sector below the count, a one where its mask bit is clear. `sect_pad_ff` gives a one where its mask bit is set.
- R4: A partial write request of length 0 leaves the mask all ones, and `sect_par_en` is 0.
- R5: A write-done pulse returns the mask to all zeros one cycle later and leaves the spare size unchanged.
- R6: A full-page write request clears bits 31:16 of spare word 0, keeps its bits 15:0, and leaves the mask at zero.
- R7: A fill pulse makes every spare word read 0xFFFFFFFF. Host writes made afterwards read back as written, with one cycle of read latency and `sp_rd_valid` marking the data.
- R8: A parity word is stored only when its sector is below the sector count and that sector's mask bit is clear. A rejected parity write leaves the target word unchanged.
- R9: A read request yields `rd_resp_valid` one cycle later. `rd_erased` is 1 exactly when bits 31:16 of spare word 0 were nonzero, and `xfer_start` is 1 only when the page is not erased. `rd_erased` holds until the next request.
- R10: Each input data word appears at `dat_out` one cycle later. It is replaced by 0xFFFFFFFF when the page state at the time of input was erased.
- R11: When a read request and a host write to spare word 0 fall in the same cycle, the erased check uses word 0 as it stood before that write. The next request sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load configuration |
| cfg_spare_bytes | input | 9 | Spare-area size in bytes |
| cfg_sect_lg | input | 4 | log2 of sector size in bytes |
| cfg_sect_cnt | input | 5 | Number of sectors in a page |
| wr_req | input | 1 | Page write request |
| wr_full | input | 1 | 1 = full page, 0 = partial |
| wr_ofs | input | 16 | Partial write byte offset |
| wr_len | input | 16 | Partial write byte length |
| wr_done | input | 1 | Write finished, restore mask |
| rd_req | input | 1 | Page read request |
| sp_fill | input | 1 | Set whole spare store to 0xFF |
| sp_wr_en | input | 1 | Host spare word write |
| sp_wr_idx | input | 5 | Host write word index |
| sp_wr_data | input | 32 | Host write data |
| sp_rd_en | input | 1 | Host spare word read |
| sp_rd_idx | input | 5 | Host read word index |
| par_we | input | 1 | Parity word from ECC engine |
| par_sect | input | 4 | Sector the parity belongs to |
| par_idx | input | 5 | Spare word index for parity |
| par_data | input | 32 | Parity word |
| dat_in_valid | input | 1 | Page data word valid |
| dat_in | input | 32 | Page data word |
| ctl_word | output | 32 | Skip mask and spare size |
| sect_par_en | output | 16 | Sectors that get parity |
| sect_pad_ff | output | 16 | Sectors padded with 0xFF |
| sp_rd_valid | output | 1 | Spare read data valid |
| sp_rd_data | output | 32 | Spare read data |
| rd_resp_valid | output | 1 | Read check result valid |
| rd_erased | output | 1 | Page is erased |
| xfer_start | output | 1 | Start page data transfer |
| dat_out_valid | output | 1 | Output data valid |
| dat_out | output | 32 | Page data or all ones |

## Verification
Two of the block's functions can fall in the same cycle: the erased check of a read request and a host update of spare word 0. The bench provokes this by first leaving word 0 with a clear marker. In a single cycle it then raises the read request and writes 0xFFFF0000 to word 0. The scoreboard expects "not erased, transfer started" for that request and "erased, no transfer" for the request that follows. A data word sent in the same cycle as a request is judged against the erased state held before that request.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int SA_MASK_W = 16;
  localparam int SA_WORD_W = 32;
  localparam int SA_SIZE_W = 9;

  function automatic logic [SA_MASK_W-1:0] sa_low_ones(input logic [4:0] cnt);
    logic [SA_MASK_W-1:0] m;
    for (int i = 0; i < SA_MASK_W; i++) m[i] = (5'(i) < cnt);
    return m;
  endfunction
endpackage

// File: rtl/sa_mask_calc.sv
module sa_mask_calc
  import sa_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int LG_W  = 4
) (
  input  logic [OFS_W-1:0]     ofs,
  input  logic [OFS_W-1:0]     len,
  input  logic [LG_W-1:0]      lg,
  output logic [SA_MASK_W-1:0] mask
);
  localparam int EW = OFS_W + 2;

  logic [EW-1:0] first_s, aligned, end_x, ssize;

  always_comb begin
    ssize   = EW'(1) << lg;
    first_s = EW'(ofs) >> lg;
    aligned = first_s << lg;
    end_x   = (aligned + EW'(len) + ssize - EW'(1)) >> lg;
  end

  for (genvar i = 0; i < SA_MASK_W; i++) begin : g_bit
    assign mask[i] = !((EW'(i) >= first_s) && (EW'(i) < end_x));
  end
endmodule

// File: rtl/sa_spare_store.sv
module sa_spare_store
  import sa_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fill,
  input  logic                 host_we,
  input  logic [IDX_W-1:0]     host_idx,
  input  logic [SA_WORD_W-1:0] host_data,
  input  logic                 par_ok,
  input  logic [IDX_W-1:0]     par_idx,
  input  logic [SA_WORD_W-1:0] par_data,
  input  logic                 clr_marker,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic                 rd_valid,
  output logic [SA_WORD_W-1:0] rd_data,
  output logic [SA_WORD_W-1:0] word0
);
  logic [SA_WORD_W-1:0] mem [WORDS];
  logic [WORDS-1:0]     written;

  logic                 we;
  logic [IDX_W-1:0]     widx;
  logic [SA_WORD_W-1:0] wdata;

  // host port has priority over the parity port on a shared cycle
  always_comb begin
    we    = host_we | par_ok;
    widx  = host_we ? host_idx  : par_idx;
    wdata = host_we ? host_data : par_data;
  end

  // RAM body: plain write and registered read so block RAM maps
  logic [SA_WORD_W-1:0] ram_q;
  always_ff @(posedge clk) begin
    if (we && widx != '0) mem[widx] <= wdata;
    ram_q <= mem[rd_idx];
  end

  // per-word written flags give the single-cycle 0xFF fill
  always_ff @(posedge clk) begin
    if (rst || fill) written <= '0;
    else if (we && widx != '0) written[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || fill) word0 <= '1;
    else if (we && widx == '0) word0 <= wdata;
    else if (clr_marker && word0[31:16] != '0) word0 <= {16'h0, word0[15:0]};
  end

  logic                 flag_q, zero_q;
  logic [SA_WORD_W-1:0] w0_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      flag_q   <= 1'b0;
      zero_q   <= 1'b0;
      w0_q     <= '1;
    end else begin
      rd_valid <= rd_en;
      flag_q   <= written[rd_idx];
      zero_q   <= (rd_idx == '0);
      w0_q     <= word0;
    end
  end

  always_comb begin
    if (zero_q)      rd_data = w0_q;
    else if (flag_q) rd_data = ram_q;
    else             rd_data = '1;
  end
endmodule

// File: rtl/sa_read_gate.sv
module sa_read_gate
  import sa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_req,
  input  logic [SA_WORD_W-1:0] word0,
  input  logic                 dat_in_valid,
  input  logic [SA_WORD_W-1:0] dat_in,
  output logic                 rd_resp_valid,
  output logic                 rd_erased,
  output logic                 xfer_start,
  output logic                 dat_out_valid,
  output logic [SA_WORD_W-1:0] dat_out
);
  logic marked;
  assign marked = (word0[31:16] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_resp_valid <= 1'b0;
      rd_erased     <= 1'b0;
      xfer_start    <= 1'b0;
      dat_out_valid <= 1'b0;
      dat_out       <= '0;
    end else begin
      rd_resp_valid <= rd_req;
      xfer_start    <= rd_req && !marked;
      if (rd_req) rd_erased <= marked;
      dat_out_valid <= dat_in_valid;
      if (dat_in_valid) dat_out <= rd_erased ? '1 : dat_in;
    end
  end
endmodule

// File: rtl/sa_page_state.sv
module sa_page_state
  import sa_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int IDX_W = $clog2(WORDS),
  parameter int OFS_W = 16,
  parameter int LG_W  = 4,
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [SA_SIZE_W-1:0] cfg_spare_bytes,
  input  logic [LG_W-1:0]      cfg_sect_lg,
  input  logic [CNT_W-1:0]     cfg_sect_cnt,
  input  logic                 wr_req,
  input  logic                 wr_full,
  input  logic [OFS_W-1:0]     wr_ofs,
  input  logic [OFS_W-1:0]     wr_len,
  input  logic                 wr_done,
  input  logic                 rd_req,
  input  logic                 sp_fill,
  input  logic                 sp_wr_en,
  input  logic [IDX_W-1:0]     sp_wr_idx,
  input  logic [SA_WORD_W-1:0] sp_wr_data,
  input  logic                 sp_rd_en,
  input  logic [IDX_W-1:0]     sp_rd_idx,
  input  logic                 par_we,
  input  logic [3:0]           par_sect,
  input  logic [IDX_W-1:0]     par_idx,
  input  logic [SA_WORD_W-1:0] par_data,
  input  logic                 dat_in_valid,
  input  logic [SA_WORD_W-1:0] dat_in,
  output logic [SA_WORD_W-1:0] ctl_word,
  output logic [SA_MASK_W-1:0] sect_par_en,
  output logic [SA_MASK_W-1:0] sect_pad_ff,
  output logic                 sp_rd_valid,
  output logic [SA_WORD_W-1:0] sp_rd_data,
  output logic                 rd_resp_valid,
  output logic                 rd_erased,
  output logic                 xfer_start,
  output logic                 dat_out_valid,
  output logic [SA_WORD_W-1:0] dat_out
);
  logic [SA_MASK_W-1:0] mask_q, mask_nx, in_page;
  logic [SA_SIZE_W-1:0] size_q;
  logic [LG_W-1:0]      lg_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 par_ok;
  logic [SA_WORD_W-1:0] word0;

  sa_mask_calc #(.OFS_W(OFS_W), .LG_W(LG_W)) u_calc (
    .ofs(wr_ofs), .len(wr_len), .lg(lg_q), .mask(mask_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      lg_q   <= '0;
      cnt_q  <= '0;
    end else if (cfg_we) begin
      size_q <= cfg_spare_bytes;
      lg_q   <= cfg_sect_lg;
      cnt_q  <= cfg_sect_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   mask_q <= '0;
    else if (wr_req && !wr_full) mask_q <= mask_nx;
    else if (wr_req)           mask_q <= '0;
    else if (wr_done)          mask_q <= '0;
  end

  assign in_page     = sa_low_ones(5'(cnt_q));
  assign ctl_word    = {mask_q, 7'b0, size_q};
  assign sect_par_en = ~mask_q & in_page;
  assign sect_pad_ff = mask_q & in_page;
  assign par_ok      = par_we && ({1'b0, par_sect} < 5'(cnt_q)) && !mask_q[par_sect];

  sa_spare_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .fill(sp_fill),
    .host_we(sp_wr_en), .host_idx(sp_wr_idx), .host_data(sp_wr_data),
    .par_ok(par_ok), .par_idx(par_idx), .par_data(par_data),
    .clr_marker(wr_req && wr_full),
    .rd_en(sp_rd_en), .rd_idx(sp_rd_idx),
    .rd_valid(sp_rd_valid), .rd_data(sp_rd_data), .word0(word0)
  );

  sa_read_gate u_gate (
    .clk(clk), .rst(rst), .rd_req(rd_req), .word0(word0),
    .dat_in_valid(dat_in_valid), .dat_in(dat_in),
    .rd_resp_valid(rd_resp_valid), .rd_erased(rd_erased),
    .xfer_start(xfer_start), .dat_out_valid(dat_out_valid), .dat_out(dat_out)
  );
endmodule

// File: rtl/sa_page_state_chk.sv
module sa_page_state_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_req,
  input logic        wr_full,
  input logic [15:0] wr_len,
  input logic        wr_done,
  input logic        rd_req,
  input logic        rd_resp_valid,
  input logic        rd_erased,
  input logic        xfer_start,
  input logic        dat_in_valid,
  input logic [31:0] dat_in,
  input logic        dat_out_valid,
  input logic [31:0] dat_out,
  input logic [31:0] ctl_word
);
  // R4
  a_r4_zero_len_all_skip: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_full && wr_len == 16'h0) |=> ctl_word[31:16] == 16'hFFFF);
  // R5
  a_r5_done_clears_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_done && !wr_req) |=> (ctl_word[31:16] == 16'h0 && $stable(ctl_word[8:0])));
  // R9
  a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_resp_valid);
  // R9
  a_r9_no_xfer_if_erased: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> (rd_resp_valid && !rd_erased));
  // R10
  a_r10_data_gate: assert property (@(posedge clk) disable iff (rst)
    dat_in_valid |=> (dat_out_valid &&
      dat_out == ($past(rd_erased) ? 32'hFFFF_FFFF : $past(dat_in))));
endmodule

bind sa_page_state sa_page_state_chk u_chk (.*);

// File: tb/sa_page_state_bench.sv
module sa_page_state_bench;
  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic        cfg_we = 0; logic [8:0] cfg_spare_bytes = 0;
  logic [3:0]  cfg_sect_lg = 0; logic [4:0] cfg_sect_cnt = 0;
  logic        wr_req = 0, wr_full = 0, wr_done = 0, rd_req = 0;
  logic [15:0] wr_ofs = 0, wr_len = 0;
  logic        sp_fill = 0, sp_wr_en = 0, sp_rd_en = 0, par_we = 0, dat_in_valid = 0;
  logic [4:0]  sp_wr_idx = 0, sp_rd_idx = 0, par_idx = 0;
  logic [3:0]  par_sect = 0;
  logic [31:0] sp_wr_data = 0, par_data = 0, dat_in = 0;
  logic [31:0] ctl_word, sp_rd_data, dat_out;
  logic [15:0] sect_par_en, sect_pad_ff;
  logic        sp_rd_valid, rd_resp_valid, rd_erased, xfer_start, dat_out_valid;

  sa_page_state u_sa_page_state (.*);

  typedef struct { string tag; logic [31:0] v; } item_t;
  item_t q_sp[$], q_resp[$], q_dat[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pop(ref item_t q[$], input logic [31:0] act, input string what);
    item_t it;
    if (q.size() == 0) chk({what, " unexpected"}, act, 32'hx);
    else begin it = q.pop_front(); chk(it.tag, act, it.v); end
  endtask

  // monitor: compares design results with queued expectations
  always @(negedge clk) if (!rst) begin
    if (sp_rd_valid)   pop(q_sp, sp_rd_data, "spare");
    if (rd_resp_valid) pop(q_resp, {30'h0, rd_erased, xfer_start}, "resp");
    if (dat_out_valid) pop(q_dat, dat_out, "data");
  end

  task automatic step(); @(negedge clk); endtask

  task automatic spr(logic [4:0] idx, logic [31:0] exp, string tag);
    sp_rd_en = 1; sp_rd_idx = idx; q_sp.push_back('{tag, exp}); step(); sp_rd_en = 0;
  endtask
  task automatic spw(logic [4:0] idx, logic [31:0] d);
    sp_wr_en = 1; sp_wr_idx = idx; sp_wr_data = d; step(); sp_wr_en = 0;
  endtask
  task automatic rdq(bit erased, string tag);
    rd_req = 1; q_resp.push_back('{tag, {30'h0, erased, !erased}}); step(); rd_req = 0;
  endtask
  task automatic dat(logic [31:0] d, logic [31:0] exp, string tag);
    dat_in_valid = 1; dat_in = d; q_dat.push_back('{tag, exp}); step(); dat_in_valid = 0;
  endtask
  task automatic wreq(bit full, logic [15:0] o, logic [15:0] l);
    wr_req = 1; wr_full = full; wr_ofs = o; wr_len = l; step(); wr_req = 0;
  endtask
  task automatic wdone(); wr_done = 1; step(); wr_done = 0; endtask
  task automatic par(logic [3:0] s, logic [4:0] i, logic [31:0] d);
    par_we = 1; par_sect = s; par_idx = i; par_data = d; step(); par_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) step(); rst = 0; step();
    chk("R1 ctl after reset", ctl_word, 32'h0);
    spr(5'd5, 32'hFFFF_FFFF, "R1 spare after reset");
    rdq(1, "R1 read after reset erased");
    step();
    // configuration: 64 spare bytes, 512-byte sectors, 4 sectors
    cfg_we = 1; cfg_spare_bytes = 9'd64; cfg_sect_lg = 4'd9; cfg_sect_cnt = 5'd4;
    step(); cfg_we = 0;
    chk("R2 ctl after cfg", ctl_word, 32'h0000_0040);
    // fill then load word 0 with marker set
    sp_fill = 1; step(); sp_fill = 0;
    spr(5'd7, 32'hFFFF_FFFF, "R7 word after fill");
    spw(5'd0, 32'hFFFF_00AB);
    spw(5'd3, 32'h1357_9BDF);
    spr(5'd0, 32'hFFFF_00AB, "R7 word0 readback");
    spr(5'd3, 32'h1357_9BDF, "R7 word3 readback");
    rdq(1, "R9 marker set erased");
    dat(32'h1122_3344, 32'hFFFF_FFFF, "R10 erased data forced");
    // full program clears marker
    wreq(1, 16'h0, 16'h0);
    chk("R6 mask after full write", ctl_word, 32'h0000_0040);
    spr(5'd0, 32'h0000_00AB, "R6 word0 marker cleared");
    rdq(0, "R9 marker clear not erased");
    dat(32'h5566_7788, 32'h5566_7788, "R10 data passes");
    // partial program covering sectors 1..2
    wreq(0, 16'd600, 16'd1000);
    chk("R3 mask mid range", ctl_word, 32'hFFF9_0040);
    chk("R3 parity enables", {16'h0, sect_par_en}, 32'h0000_0006);
    chk("R3 pad sectors", {16'h0, sect_pad_ff}, 32'h0000_0009);
    par(4'd1, 5'd10, 32'hA5A5_A5A5);
    par(4'd0, 5'd11, 32'h5A5A_5A5A);
    par(4'd5, 5'd12, 32'h0F0F_0F0F);
    spr(5'd10, 32'hA5A5_A5A5, "R8 parity accepted");
    spr(5'd11, 32'hFFFF_FFFF, "R8 masked sector rejected");
    spr(5'd12, 32'hFFFF_FFFF, "R8 out of range rejected");
    wdone();
    chk("R5 mask restored", ctl_word, 32'h0000_0040);
    // zero length
    wreq(0, 16'd512, 16'd0);
    chk("R4 zero length mask", ctl_word, 32'hFFFF_0040);
    chk("R4 zero length no parity", {16'h0, sect_par_en}, 32'h0);
    wdone();
    // last sector only, aligned
    wreq(0, 16'd1536, 16'd512);
    chk("R3 last sector", ctl_word, 32'hFFF7_0040);
    wdone();
    // first byte only
    wreq(0, 16'd0, 16'd1);
    chk("R3 first sector", ctl_word, 32'hFFFE_0040);
    wdone();
    chk("R5 spare size kept", ctl_word, 32'h0000_0040);
    // same-cycle read check and word0 write
    sp_wr_en = 1; sp_wr_idx = 5'd0; sp_wr_data = 32'hFFFF_0000;
    rd_req = 1; q_resp.push_back('{"R11 same-cycle uses old word0", 32'h1});
    dat_in_valid = 1; dat_in = 32'hCAFE_0001; q_dat.push_back('{"R11 data with old state", 32'hCAFE_0001});
    step(); sp_wr_en = 0; rd_req = 0; dat_in_valid = 0;
    rdq(1, "R11 next read sees new word0");
    dat(32'hCAFE_0002, 32'hFFFF_FFFF, "R11 data after erased");
    // fill again wipes stored parity
    sp_fill = 1; step(); sp_fill = 0;
    spr(5'd10, 32'hFFFF_FFFF, "R7 refill clears word");
    repeat (3) step();
    chk("scoreboard drained", q_sp.size() + q_resp.size() + q_dat.size(), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule